// File: doc/BRIEF.md
# SPI Mode-3 Byte Master

This block is a single-target SPI master. It takes a start strobe and a transmit word from the host and drives an active-low select line. It produces a serial clock from the system clock and exchanges one word full duplex: the outgoing word goes out on `mosi` while the target's word is collected from `miso`. The serial clock idles high. The master changes `mosi` on rising serial-clock edges and samples `miso` on falling edges. Both words travel most significant bit first.

The serial-clock half period is `HALF_DIV` system clocks. The default of 14 gives about 3.57 MHz from a 100 MHz system clock. The select line goes low one half period before the first clock edge and rises one half period after the last one. That rise closes the transfer. In the same cycle `done` pulses once and the received word appears on `rx_byte`. `rx_byte` then holds that value until the next transfer completes.

Top module: `spi_m3_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take their idle values: `cs_n`=1, `sclk`=1, `mosi`=0, `busy`=0, `done`=0 and `rx_byte`=0.
- R2: When `start` is sampled high while `busy` is 0, then after that edge `cs_n`=0, `busy`=1 and `mosi` equals bit 7 of `tx_byte`.
- R3: `sclk` stays high after `cs_n` falls. Its first falling edge comes exactly `HALF_DIV` system clocks after the edge that lowered `cs_n`.
- R4: Each transfer has exactly 8 falling and 8 rising `sclk` edges, which alternate and are spaced `HALF_DIV` system clocks apart. `sclk` is high whenever `cs_n` is high.
- R5: `mosi` carries `tx_byte` with bit 7 first. It changes only at rising `sclk` edges and is stable at every falling edge.
- R6: The master samples `miso` at each falling `sclk` edge, with bit 7 first. After the transfer, `rx_byte` equals the 8 bits the target presented.
- R7: `cs_n` rises `HALF_DIV` system clocks after the eighth rising edge, which is 16·`HALF_DIV` clocks after the first falling edge. In that same cycle `busy` goes 0 and `done` is 1 for exactly one cycle.
- R8: A `start` sampled while `busy` is 1 is ignored. This includes the edge at which the transfer ends. The word being sent is unchanged, and `cs_n` stays high afterwards.
- R9: `rx_byte` changes only in the cycle `done` is high. A `start` sampled in the `done` cycle begins a new transfer at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| tx_byte | input | DATA_W | Word to send, captured at start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer closes |
| rx_byte | output | DATA_W | Last received word |
| cs_n | output | 1 | Active-low target select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |

## Verification
Two events can meet at the same clock edge: the final half-period tick that closes the transfer, and a new `start` from the host. The bench drives `start` so that it is sampled exactly on the closing edge. It then checks that no second transfer follows and that `cs_n` stays high. In a separate test, `start` is held into the `done` cycle, and the bench checks that a fresh transfer begins immediately with the new word, whose bytes the behavioural target must then exchange correctly. Random words in both directions are compared with the target model's captures. Edge counts and half-period spacing are also measured on every transfer.

// File: rtl/spi_m3_pkg.sv
// Shared types for the mode-3 SPI master.
// Assumes nothing beyond a standard SystemVerilog package scope.
package spi_m3_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/spi_m3_tick.sv
// Half-period tick generator.
// While run is high, it emits one tick every HALF_DIV system clocks, and the
// first tick comes HALF_DIV clocks after run rises.
// Assumes HALF_DIV >= 2.
module spi_m3_tick #(
    parameter int HALF_DIV = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within a half period; restart whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the last count of each half period.
    assign tick = run && (cnt == LAST);

    // Ticks are never adjacent, so each half period lasts at least two clocks.
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_m3_seq.sv
// Transfer sequencer.
// Owns the select line, the serial clock, busy and done. It walks through
// 2*DATA_W+1 half periods: a lead-in, alternating fall/rise edges, and a
// trail-out that closes the transfer.
// Assumes one tick per half period from spi_m3_tick.
module spi_m3_seq
    import spi_m3_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic run,
    output logic load,
    output logic fall_ev,
    output logic shift_ev,
    output logic finish,
    output logic busy,
    output logic done,
    output logic cs_n,
    output logic sclk
);
    localparam int LAST_H = 2 * DATA_W;
    localparam int HW = $clog2(LAST_H + 1);
    localparam logic [HW-1:0] H_END  = HW'(LAST_H);
    localparam logic [HW-1:0] H_LROS = HW'(LAST_H - 1);

    seq_state_e    state;
    logic [HW-1:0] hcnt;
    logic          rise_ev;

    // Decode which serial-clock event the current tick represents.
    always_comb begin
        run      = (state == SEQ_RUN);
        load     = (state == SEQ_IDLE) && start;
        fall_ev  = run && tick && !hcnt[0] && (hcnt != H_END);
        rise_ev  = run && tick && hcnt[0];
        shift_ev = rise_ev && (hcnt != H_LROS);
        finish   = run && tick && (hcnt == H_END);
    end

    // Sequence state, half-period index and the line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            hcnt  <= '0;
            cs_n  <= 1'b1;
            sclk  <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state <= SEQ_RUN;
                hcnt  <= '0;
                cs_n  <= 1'b0;
                busy  <= 1'b1;
            end else if (run && tick) begin
                hcnt <= hcnt + 1'b1;
                if (fall_ev) sclk <= 1'b0;
                if (rise_ev) sclk <= 1'b1;
                if (finish) begin
                    state <= SEQ_IDLE;
                    cs_n  <= 1'b1;
                    busy  <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    // The serial clock rests high whenever the target is deselected.
    assert_sclk_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // Done is a single-cycle pulse.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // A start while busy leaves the select line low.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !finish) |=> !cs_n);
endmodule

// File: rtl/spi_m3_shreg.sv
// Data path: a transmit shifter feeding mosi and a receive shifter fed by
// miso, plus the held result word.
// Assumes load, shift, sample and finish come from spi_m3_seq and never
// coincide.
module spi_m3_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              shift,
    input  logic              sample,
    input  logic              miso,
    input  logic              finish,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;

    // Transmit shifter: capture at start, move toward the MSB on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= tx_data;
        end else if (shift) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Receive shifter: take miso into the LSB on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample) begin
            rx_q <= {rx_q[DATA_W-2:0], miso};
        end
    end

    // Result word: published when the transfer closes, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (finish) begin
            rx_data <= rx_q;
        end
    end

    assign mosi = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_m3_master.sv
// Mode-3 SPI master for one target, one word per transfer.
// Joins the tick generator, the sequencer and the data path.
// Assumes miso is stable around falling sclk edges and that the host holds
// tx_byte valid in the cycle start is sampled.
module spi_m3_master #(
    parameter int HALF_DIV = 14,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic run, tick, load, fall_ev, shift_ev, finish;

    spi_m3_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_m3_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .run      (run),
        .load     (load),
        .fall_ev  (fall_ev),
        .shift_ev (shift_ev),
        .finish   (finish),
        .busy     (busy),
        .done     (done),
        .cs_n     (cs_n),
        .sclk     (sclk)
    );

    spi_m3_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tx_data (tx_byte),
        .shift   (shift_ev),
        .sample  (fall_ev),
        .miso    (miso),
        .finish  (finish),
        .mosi    (mosi),
        .rx_data (rx_byte)
    );

    // Data toward the target never moves on a falling serial-clock edge.
    assert_mosi_stable_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(mosi));
    // The result word only moves in the done cycle.
    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_byte));
endmodule

// File: tb/spi_m3_master_tb.sv
module spi_m3_master_tb;
    localparam int HD = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       busy, done, cs_n, sclk, mosi;
    logic [7:0] rx_byte;
    logic       miso = 1'b0;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    spi_m3_master #(.HALF_DIV(HD), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .busy(busy), .done(done), .rx_byte(rx_byte),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Behavioural target: sample on falling sclk, launch on rising sclk.
    logic [7:0] sl_tx = '0;
    logic [7:0] sl_sh = '0;
    logic [7:0] sl_rx = '0;
    int fall_cnt = 0;
    int rise_cnt = 0;

    always @(negedge cs_n) begin
        sl_sh = sl_tx;
        miso = sl_sh[7];
        fall_cnt = 0;
        rise_cnt = 0;
    end
    always @(negedge sclk) if (cs_n == 1'b0) begin
        sl_rx = {sl_rx[6:0], mosi};
        fall_cnt++;
    end
    always @(posedge sclk) if (cs_n == 1'b0) begin
        rise_cnt++;
        sl_sh = {sl_sh[6:0], 1'b0};
        miso = sl_sh[7];
    end

    function automatic int exp_lead();
        return HD;
    endfunction
    function automatic int exp_body();
        return 16 * HD;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive start at the current negedge; it is sampled by the next posedge.
    task automatic begin_xfer(input logic [7:0] tx, input logic [7:0] stx);
        sl_tx = stx;
        tx_byte = tx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0, "R2 cs_n", int'(cs_n), 0);
        chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        chk(mosi == tx[7], "R2 mosi msb", int'(mosi), int'(tx[7]));
    endtask

    // pokes: 0 none, 1 start mid-transfer, 2 start sampled on closing edge.
    task automatic body_xfer(input logic [7:0] tx, input logic [7:0] stx, input int poke);
        int n = 0;
        int m = 0;
        while (sclk == 1'b1 && n < 4 * HD) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_lead(), "R3 lead", n, exp_lead());
        while (done == 1'b0 && m < 20 * HD) begin
            if (poke == 1 && m == 5 * HD) begin
                start = 1'b1;
                tx_byte = ~tx;
            end else if (poke == 2 && m == exp_body() - 1) begin
                start = 1'b1;
                tx_byte = ~tx;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            m++;
        end
        start = 1'b0;
        chk(m == exp_body(), "R7 trail timing", m, exp_body());
        chk(cs_n == 1'b1, "R7 cs_n high", int'(cs_n), 1);
        chk(busy == 1'b0, "R7 busy low", int'(busy), 0);
        chk(fall_cnt == 8, "R4 falls", fall_cnt, 8);
        chk(rise_cnt == 8, "R4 rises", rise_cnt, 8);
        chk(sl_rx == tx, "R5 target got", int'(sl_rx), int'(tx));
        chk(rx_byte == stx, "R6 rx_byte", int'(rx_byte), int'(stx));
    endtask

    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] stx, input int poke);
        @(negedge clk);
        begin_xfer(tx, stx);
        body_xfer(tx, stx, poke);
        @(negedge clk);
        chk(done == 1'b0, "R7 done width", int'(done), 0);
        chk(rx_byte == stx, "R9 rx hold", int'(rx_byte), int'(stx));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005_EED1));
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b1, "R1 sclk", int'(sclk), 1);
        chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags", int'({busy, done}), 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", int'(rx_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner words.
        run_xfer(8'h00, 8'hFF, 0);
        run_xfer(8'hFF, 8'h00, 0);
        run_xfer(8'hA5, 8'h5A, 0);
        run_xfer(8'h80, 8'h01, 0);

        // Start while busy: ignored.
        run_xfer(8'h3C, 8'hC3, 1);
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R8 no restart mid", int'(cs_n), 1);

        // Start sampled on the closing edge: ignored.
        run_xfer(8'h69, 8'h96, 2);
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R8 no restart at end", int'(cs_n), 1);
        chk(rx_byte == 8'h96, "R8 rx intact", int'(rx_byte), 8'h96);

        // Start during the done cycle: accepted at once.
        @(negedge clk);
        begin_xfer(8'h12, 8'h34);
        body_xfer(8'h12, 8'h34, 0);
        begin_xfer(8'hE7, 8'h7E);
        chk(busy == 1'b1, "R9 back-to-back", int'(busy), 1);
        body_xfer(8'hE7, 8'h7E, 0);

        // Random words in both directions.
        for (int i = 0; i < 30; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            run_xfer(a, b, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule